// File: doc/BRIEF.md
# Cascadable Serial DAC Code Register

This block is the digital front end of a serially programmed voltage-output converter. A host drives three wires: an active-low chip select, a serial clock and a serial data line. While chip select is low, each rising clock edge shifts one bit into a 16-bit frame register, MSB first. When chip select returns high, the bottom 12 bits of that register are copied into the converter code latch, and a one-cycle valid strobe marks the update. The top 4 bits of a frame carry no code, so an unchained device needs only the last 12 bits of a write.

The bit that leaves the top of the frame register drives a serial output. That output changes on the falling clock edge while the device is selected, and it holds its value while deselected. Wiring the serial output of one device to the serial input of the next forms a chain: a host shifts 16 bits per device, last device first, and one chip-select rise updates all of them. The `RES` parameter chooses 8, 10 or 12 meaningful code bits. The latch is always 12 bits wide, and the bits below the resolution are held at zero. An ideal converter then produces 2·Vref·code/2^RES.

The serial inputs are asynchronous to `clk`. They pass through `SYNC` flip-flop stages, and every edge is detected on the synchronised copies.

Top module: `sdac_frontend`

## Requirements
- R1: During reset and after it, `dac_code` is 0, `code_valid` is 0 and `sdo` is 0. The frame register is also cleared, so a select/deselect with no clocks latches code 0.
- R2: Serial clock edges seen while chip select is high shift nothing. A later select/deselect with no clocks latches the same code as before.
- R3: On each chip-select rise, `dac_code` takes the last 12 bits shifted in (bit 11 = earliest of those 12, MSB-first order). The 4 leading bits of a 16-bit frame do not affect the code.
- R4: `code_valid` pulses high for exactly one `clk` cycle per chip-select rise. `dac_code` changes only in that cycle.
- R5: For `RES` < 12, the code occupies `dac_code[11:12-RES]`, and the low 12-RES bits latch as 0 whatever was shifted in. With `RES`=8, code 128 corresponds to an ideal output equal to Vref.
- R6: A chip-select rise after fewer than 12 clocks latches whatever the low 12 frame bits hold: older bits shifted up by the new ones.
- R7: `sdo` updates only on a falling serial clock edge while selected. It then shows the bit that entered 16 counted rising edges earlier, so chained devices each receive their own 16-bit frame.
- R8: While chip select is high, `sdo` holds the last bit it drove.
- R9: If a chip-select rise and a serial-clock rise are seen in the same synchronised sample, the clock edge is not taken. The latch gets the frame as it stood.
- R10: If the serial clock is already high when chip select falls, that level is not a data edge. The first bit is taken on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial wires |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cs_n | input | 1 | Active-low chip select; its rising edge loads the code |
| sclk | input | 1 | Serial clock: rising edge shifts in, falling edge shifts out |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out to the next device in a chain |
| dac_code | output | 12 | Latched converter code, left-aligned to the resolution |
| code_valid | output | 1 | One-cycle strobe when `dac_code` is loaded |

## Verification
Two actions can land in the same synchronised sample: a serial-clock rise that would shift a bit and a chip-select rise that loads the latch. The bench provokes this by releasing chip select and raising the clock at the same instant after ten bits. It expects the latch to hold the ten-bit frame without the extra bit, and it expects the later falling edge, now deselected, to leave the serial output unchanged. The main sweep drives two chained instances (12-bit then 8-bit) through all 256 codes of the second device. Both latches are checked against arithmetic expectations, and the serial output is checked after every bit.

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
  parameter int RES     = 12,
  parameter int SYNC    = 2,
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic [CODE_W-1:0] dac_code,
  output logic              code_valid
);

  localparam int PAD = CODE_W - RES;
  localparam logic [CODE_W-1:0] KEEP = CODE_W'(((1 << RES) - 1) << PAD);

  logic [SYNC-1:0]    cs_pipe, ck_pipe, di_pipe;
  logic               cs_d, ck_d;
  logic [FRAME_W-1:0] shreg;

  wire cs_q    = cs_pipe[SYNC-1];
  wire ck_q    = ck_pipe[SYNC-1];
  wire di_q    = di_pipe[SYNC-1];
  wire ck_rise = ck_q & ~ck_d & ~cs_q;
  wire ck_fall = ~ck_q & ck_d & ~cs_q;
  wire cs_rise = cs_q & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe <= '1;
      ck_pipe <= '0;
      di_pipe <= '0;
      cs_d    <= 1'b1;
      ck_d    <= 1'b0;
    end else begin
      cs_pipe <= {cs_pipe[SYNC-2:0], cs_n};
      ck_pipe <= {ck_pipe[SYNC-2:0], sclk};
      di_pipe <= {di_pipe[SYNC-2:0], sdi};
      cs_d    <= cs_q;
      ck_d    <= ck_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      sdo        <= 1'b0;
      dac_code   <= '0;
      code_valid <= 1'b0;
    end else begin
      if (ck_rise) shreg <= {shreg[FRAME_W-2:0], di_q};
      if (ck_fall) sdo <= shreg[FRAME_W-1];
      if (cs_rise) dac_code <= shreg[CODE_W-1:0] & KEEP;
      code_valid <= cs_rise;
    end
  end

  // R2, R9: deselected samples never move the frame
  a_r2_hold_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> $stable(shreg));

  // R4: latch moves only together with the strobe
  a_r4_code_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> code_valid);

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |=> !code_valid);

  // R7: serial out changes only after a counted falling edge
  a_r7_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(ck_fall));

  // R8: serial out frozen while deselected
  a_r8_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> $stable(sdo));

  // R5: padding bits stay clear
  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> ((dac_code & ~KEEP) == '0));

endmodule

// File: tb/sdac_frontend_bench.sv
module sdac_frontend_bench;

  localparam int H       = 4;
  localparam int VREF_UV = 2048000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo_a, sdo_b, valid_a, valid_b;
  logic [11:0] code_a, code_b;

  always #10 clk = ~clk;

  sdac_frontend #(.RES(12)) u_sdac_frontend (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo_a), .dac_code(code_a), .code_valid(valid_a));

  sdac_frontend #(.RES(8)) u_sdac_frontend_r8 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdo_a),
    .sdo(sdo_b), .dac_code(code_b), .code_valid(valid_b));

  int checks = 0;
  int errors = 0;
  int vcnt_a = 0;
  int vcnt_b = 0;
  logic [15:0] model_a = '0;
  logic [15:0] model_b = '0;
  logic        model_sdo = 1'b0;

  always @(posedge clk) begin
    if (rst_n && valid_a) vcnt_a++;
    if (rst_n && valid_b) vcnt_b++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    step(H);
    sclk = 1'b1;
    if (!cs_n) begin
      model_b = {model_b[14:0], model_sdo};
      model_a = {model_a[14:0], b};
    end
    step(H);
    sclk = 1'b0;
    if (!cs_n) model_sdo = model_a[15];
    step(H);
    check(cs_n ? "R8 sdo held" : "R7 sdo", int'(sdo_a), int'(model_sdo));
  endtask

  task automatic send_word(input logic [15:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic select();
    cs_n = 1'b0;
    step(H);
  endtask

  task automatic deselect_check(input string tag);
    int va, vb;
    va = vcnt_a;
    vb = vcnt_b;
    cs_n = 1'b1;
    step(H + 2);
    check({tag, " code_a"}, int'(code_a), int'(model_a[11:0]));
    check({tag, " code_b"}, int'(code_b), int'(model_b[11:0] & 12'hFF0));
    check("R4 one strobe", vcnt_a - va, 1);
    check("R4 one strobe b", vcnt_b - vb, 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [11:0] a12;
    int va;
    step(5);
    check("R1 reset code", int'(code_a), 0);
    check("R1 reset valid", int'(valid_a), 0);
    check("R1 reset sdo", int'(sdo_a), 0);
    rst_n = 1'b1;
    step(3);
    check("R1 after reset code_b", int'(code_b), 0);
    select();
    deselect_check("R1 cleared frame");

    // R3: full frame, leading nibble ignored
    select();
    send_word(16'hF3C5, 16);
    deselect_check("R3 frame");
    check("R3 literal", int'(code_a), 12'h3C5);

    // R2: clocks while deselected are ignored
    send_word(16'h0A0A, 16);
    select();
    deselect_check("R2 no shift");
    check("R2 literal", int'(code_a), 12'h3C5);

    // R6: partial frame of 5 bits
    select();
    send_word(16'h0013, 5);
    deselect_check("R6 partial");
    check("R6 literal", int'(code_a), 12'h8B3);

    // R9: chip-select rise together with clock rise
    select();
    send_word(16'h02D9, 10);
    va = vcnt_a;
    sdi = 1'b1;
    step(H);
    cs_n = 1'b1;
    sclk = 1'b1;
    step(H + 2);
    check("R9 collision code", int'(code_a), int'(model_a[11:0]));
    check("R9 strobe", vcnt_a - va, 1);
    sclk = 1'b0;
    step(H);
    check("R9 sdo after deselected fall", int'(sdo_a), int'(model_sdo));

    // R10: clock already high at select
    sclk = 1'b1;
    step(H);
    cs_n = 1'b0;
    step(H);
    sclk = 1'b0;
    model_sdo = model_a[15];
    step(H);
    send_word(16'h0555, 11);
    deselect_check("R10 no stray edge");

    // R5, R7: chained sweep over all 8-bit codes
    for (int v = 0; v < 256; v++) begin
      logic [7:0]  c;
      logic [15:0] fb, fa;
      c   = 8'(v);
      a12 = {c, c[7:4]} ^ 12'hA5C;
      fa  = {c[3:0], a12};
      fb  = {~c[3:0], c, ~c[3:0] | 4'h1};
      select();
      send_word(fb, 16);
      send_word(fa, 16);
      deselect_check("R7 chain");
      check("R3 sweep a", int'(code_a), int'(a12));
      check("R5 sweep b", int'(code_b), int'({c, 4'h0}));
      if (v == 128 || v == 0)
        check("R5 ideal output", (2 * VREF_UV / 256) * int'(code_b[11:4]),
              (v == 128) ? VREF_UV : 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule